// File: doc/BRIEF.md
# Streaming Matrix-Vector Operand Loader and Result Unloader

This block sits between a host DMA engine and a fully parallel matrix-vector compute core. A slave AXI4-Stream port accepts one 32-bit single-precision word per beat. The block keeps every word of a square N×N matrix and the matching N-element vector in local registers. Once the whole operand set is present, it pulses a start strobe to the core and waits for the core's completion strobe.

It then captures the N-word result vector and sends it out on a master AXI4-Stream port, one word per beat, with TLAST on the final word. While the block computes or sends, the input port is closed, so a new frame cannot overwrite operands that are still in use. When the last result has been handed over, the block is ready for the next frame. The arithmetic lives in the core and is outside this block.

Top module: `mvs_stream_ctrl`

## Requirements
- R1: After synchronous active-low reset, s_tready is 1, m_tvalid is 0, m_tlast is 0 and core_start is 0.
- R2: A frame is N*N+N accepted words. The first N*N words form the matrix in row-major order, so matrix word k = row*N+col appears on core_mat[k*W +: W]. The next N words form the vector, and vector word j appears on core_vec[j*W +: W].
- R3: core_start is high for exactly one cycle, namely the cycle right after the edge at which the final word of a frame is accepted, and at no other time.
- R4: s_tready is 0 from the edge that accepts the final input word until the edge that accepts the final result word, and s_tready and m_tvalid are never high together.
- R5: core_done has no effect unless the block is waiting for the core; while it waits, m_tvalid stays 0.
- R6: core_res is captured at the edge where core_done is seen while waiting. From the next cycle, m_tvalid is 1 and the words come out in order, result word i being core_res[i*W +: W].
- R7: While m_tvalid is 1 and m_tready is 0, m_tvalid, m_tdata and m_tlast hold their values.
- R8: m_tlast is 1 only together with result word N-1 and with m_tvalid.
- R9: After the final result word is accepted, the next cycle shows s_tready 1 and m_tvalid 0, and a following frame is processed in full.
- R10: Input beats offered while s_tready is 0 are dropped and leave core_mat and core_vec unchanged.
- R11: A reset in the middle of a frame clears the word count, so the next frame needs a full N*N+N words before core_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_tdata | input | W | Input operand word |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Block accepts input |
| m_tdata | output | W | Result word |
| m_tvalid | output | 1 | Result word valid |
| m_tready | input | 1 | Downstream accepts result |
| m_tlast | output | 1 | Marks the final result word |
| core_start | output | 1 | One-cycle start strobe to the core |
| core_done | input | 1 | Completion strobe from the core |
| core_mat | output | N*N*W | Matrix operands, row-major |
| core_vec | output | N*W | Vector operands |
| core_res | input | N*W | Result vector from the core |

## Verification
The assertions take for granted three things about the inputs: the host sends whole frames, the core raises core_done only after it has seen core_start, and core_res is valid in the cycle core_done is high. The bench acts as the core. It pulses core_done once per start after a fixed latency taken from its vector table, with a result computed from the core_mat and core_vec ports. The only core_done it raises outside a computation is a deliberate one, used to check that such a strobe is ignored. Backpressure on the result port is applied only while a word is valid. Input beats offered while the port is closed are junk words that the bench never expects to see stored.

// File: rtl/mvs_pkg.sv
package mvs_pkg;
   typedef enum logic [1:0] {
      ST_LOAD    = 2'd0,
      ST_COMPUTE = 2'd1,
      ST_SEND    = 2'd2
   } mvs_state_e;
endpackage

// File: rtl/mvs_operand_store.sv
module mvs_operand_store #(
   parameter int N = 4,
   parameter int W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   output logic             wr_final,
   output logic [N*N*W-1:0] mat,
   output logic [N*W-1:0]   vec
);
   localparam int TOTAL = N*N + N;
   localparam int CW    = $clog2(TOTAL);

   logic [CW-1:0] cnt;
   logic [W-1:0]  words [TOTAL];

   assign wr_final = (cnt == CW'(TOTAL-1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (wr_en)
         cnt <= wr_final ? '0 : cnt + 1'b1;
   end

   for (genvar k = 0; k < TOTAL; k++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_en && cnt == CW'(k))
            words[k] <= wr_data;
      end
      if (k < N*N) begin : g_mat
         assign mat[k*W +: W] = words[k];
      end else begin : g_vec
         assign vec[(k-N*N)*W +: W] = words[k];
      end
   end

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(TOTAL-1));
endmodule

// File: rtl/mvs_result_unload.sv
module mvs_result_unload #(
   parameter int N        = 4,
   parameter int W        = 32,
   parameter bit USE_SHIFT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           capture,
   input  logic           pop,
   input  logic [N*W-1:0] res_in,
   output logic [W-1:0]   data,
   output logic           last
);
   localparam int IW = $clog2(N);

   logic [IW-1:0]  idx;
   logic [N*W-1:0] held;

   assign last = (idx == IW'(N-1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (capture)
         idx <= '0;
      else if (pop && !last)
         idx <= idx + 1'b1;
   end

   if (USE_SHIFT) begin : g_shift
      always_ff @(posedge clk) begin
         if (capture)
            held <= res_in;
         else if (pop)
            held <= held >> W;
      end
      assign data = held[W-1:0];
   end else begin : g_mux
      always_ff @(posedge clk) begin
         if (capture)
            held <= res_in;
      end
      assign data = held[idx*W +: W];
   end
endmodule

// File: rtl/mvs_stream_ctrl.sv
module mvs_stream_ctrl #(
   parameter int N         = 4,
   parameter int W         = 32,
   parameter bit USE_SHIFT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     s_tdata,
   input  logic             s_tvalid,
   output logic             s_tready,
   output logic [W-1:0]     m_tdata,
   output logic             m_tvalid,
   input  logic             m_tready,
   output logic             m_tlast,
   output logic             core_start,
   input  logic             core_done,
   output logic [N*N*W-1:0] core_mat,
   output logic [N*W-1:0]   core_vec,
   input  logic [N*W-1:0]   core_res
);
   import mvs_pkg::*;

   if (N < 2) begin : g_chk_n
      $error("mvs_stream_ctrl: N must be at least 2");
   end
   if (W < 1) begin : g_chk_w
      $error("mvs_stream_ctrl: W must be positive");
   end

   mvs_state_e state;
   logic       start_q;
   logic       in_beat, wr_final, capture, pop, res_last;

   assign s_tready = (state == ST_LOAD);
   assign m_tvalid = (state == ST_SEND);
   assign in_beat  = s_tvalid && s_tready;
   assign capture  = (state == ST_COMPUTE) && core_done;
   assign pop      = m_tvalid && m_tready;
   assign m_tlast  = m_tvalid && res_last;
   assign core_start = start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_LOAD;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (state)
            ST_LOAD: if (in_beat && wr_final) begin
               state   <= ST_COMPUTE;
               start_q <= 1'b1;
            end
            ST_COMPUTE: if (core_done) state <= ST_SEND;
            ST_SEND:    if (pop && res_last) state <= ST_LOAD;
            default:    state <= ST_LOAD;
         endcase
      end
   end

   mvs_operand_store #(.N(N), .W(W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(in_beat), .wr_data(s_tdata),
      .wr_final(wr_final), .mat(core_mat), .vec(core_vec));

   mvs_result_unload #(.N(N), .W(W), .USE_SHIFT(USE_SHIFT)) u_unload (
      .clk(clk), .rst_n(rst_n), .capture(capture), .pop(pop),
      .res_in(core_res), .data(m_tdata), .last(res_last));

   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);
   assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_start) |-> $past(in_beat));
   assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_tready && m_tvalid));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
   assert_last_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> m_tvalid);
   assert_reopen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && m_tlast) |=> (s_tready && !m_tvalid));
endmodule

// File: tb/tb_mvs_stream_ctrl.sv
`timescale 1ns/1ps
module tb_mvs_stream_ctrl;
   localparam int N     = 3;
   localparam int W     = 32;
   localparam int TOTAL = N*N + N;
   localparam int NV    = 4;

   localparam logic [31:0] V_SEED [NV] = '{32'h1234_5678, 32'hDEAD_0001, 32'h0BAD_F00D, 32'h7777_1111};
   localparam int          V_LAT  [NV] = '{1, 3, 6, 2};
   localparam bit          V_BP   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};
   localparam bit          V_JUNK [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] s_tdata = '0;
   logic s_tvalid = 1'b0, m_tready = 1'b0, core_done = 1'b0;
   logic s_tready, m_tvalid, m_tlast, core_start;
   logic [W-1:0] m_tdata;
   logic [N*N*W-1:0] core_mat;
   logic [N*W-1:0] core_vec;
   logic [N*W-1:0] core_res = '0;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   logic [31:0] wd [TOTAL];
   logic [31:0] ex [N];

   always #4 clk = ~clk;

   mvs_stream_ctrl #(.N(N), .W(W)) dut (
      .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
      .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
      .m_tready(m_tready), .m_tlast(m_tlast), .core_start(core_start),
      .core_done(core_done), .core_mat(core_mat), .core_vec(core_vec),
      .core_res(core_res));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic make_words(input logic [31:0] seed);
      for (int k = 0; k < TOTAL; k++)
         wd[k] = (seed * 32'h0100_0193) + (k * 32'h9E37_79B9) ^ (32'(k) << 16);
      for (int i = 0; i < N; i++) begin
         ex[i] = '0;
         for (int j = 0; j < N; j++)
            ex[i] = ex[i] ^ (wd[i*N+j] + wd[N*N+j]);
      end
   endtask

   task automatic run_frame(input int lat, input bit bp, input bit junk);
      logic [N*N*W-1:0] mat_snap;
      for (int k = 0; k < TOTAL; k++) begin
         @(negedge clk);
         chk(s_tready == 1'b1, "R4 ready during load", 32'(s_tready), 32'd1);
         chk(core_start == 1'b0, "R3 no early start", 32'(core_start), 32'd0);
         s_tvalid = 1'b1;
         s_tdata  = wd[k];
      end
      @(negedge clk);
      s_tvalid = 1'b0;
      chk(core_start == 1'b1, "R3 start after final word", 32'(core_start), 32'd1);
      chk(s_tready == 1'b0, "R4 closed while computing", 32'(s_tready), 32'd0);
      for (int k = 0; k < N*N; k++)
         chk(core_mat[k*W +: W] == wd[k], "R2 matrix word", core_mat[k*W +: W], wd[k]);
      for (int j = 0; j < N; j++)
         chk(core_vec[j*W +: W] == wd[N*N+j], "R2 vector word", core_vec[j*W +: W], wd[N*N+j]);
      for (int i = 0; i < N; i++) begin
         logic [31:0] acc;
         acc = '0;
         for (int j = 0; j < N; j++)
            acc = acc ^ (core_mat[(i*N+j)*W +: W] + core_vec[j*W +: W]);
         core_res[i*W +: W] = acc;
      end
      mat_snap = core_mat;
      for (int c = 0; c < lat; c++) begin
         if (junk) begin
            s_tvalid = 1'b1;
            s_tdata  = 32'hBADD_CAFE;
         end
         @(negedge clk);
         chk(core_start == 1'b0, "R3 single-cycle start", 32'(core_start), 32'd0);
         chk(m_tvalid == 1'b0, "R5 no output while waiting", 32'(m_tvalid), 32'd0);
      end
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
      core_res  = '0;
      s_tvalid  = junk;
      for (int i = 0; i < N; i++) begin
         if (bp) begin
            m_tready = 1'b0;
            chk(m_tvalid == 1'b1, "R6 valid", 32'(m_tvalid), 32'd1);
            chk(m_tdata == ex[i], "R6 result word", m_tdata, ex[i]);
            @(negedge clk);
            chk(m_tvalid == 1'b1 && m_tdata == ex[i], "R7 hold under backpressure", m_tdata, ex[i]);
            chk(m_tlast == (i == N-1), "R7 tlast hold", 32'(m_tlast), 32'(i == N-1));
         end
         chk(m_tvalid == 1'b1, "R6 valid", 32'(m_tvalid), 32'd1);
         chk(m_tdata == ex[i], "R6 result word", m_tdata, ex[i]);
         chk(m_tlast == (i == N-1), "R8 tlast position", 32'(m_tlast), 32'(i == N-1));
         chk(s_tready == 1'b0, "R4 closed while sending", 32'(s_tready), 32'd0);
         m_tready = 1'b1;
         @(negedge clk);
         m_tready = 1'b0;
      end
      s_tvalid = 1'b0;
      chk(s_tready == 1'b1, "R9 reopen after last", 32'(s_tready), 32'd1);
      chk(m_tvalid == 1'b0, "R9 output idle", 32'(m_tvalid), 32'd0);
      chk(core_mat == mat_snap, "R10 operands untouched by dropped beats", core_mat[31:0], mat_snap[31:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(s_tready == 1'b1, "R1 reset ready", 32'(s_tready), 32'd1);
      chk(m_tvalid == 1'b0, "R1 reset valid", 32'(m_tvalid), 32'd0);
      chk(m_tlast == 1'b0, "R1 reset last", 32'(m_tlast), 32'd0);
      chk(core_start == 1'b0, "R1 reset start", 32'(core_start), 32'd0);

      // R5: stray done while loading is ignored
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
      chk(m_tvalid == 1'b0, "R5 stray done ignored", 32'(m_tvalid), 32'd0);
      chk(s_tready == 1'b1, "R5 still loading", 32'(s_tready), 32'd1);

      for (int v = 0; v < NV; v++) begin
         make_words(V_SEED[v]);
         run_frame(V_LAT[v], V_BP[v], V_JUNK[v]);
      end

      // R11: reset in the middle of a frame restarts the count
      make_words(32'h5A5A_0F0F);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         s_tvalid = 1'b1;
         s_tdata  = 32'hFFFF_0000 + 32'(k);
      end
      @(negedge clk);
      s_tvalid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(s_tready == 1'b1, "R11 ready after mid-frame reset", 32'(s_tready), 32'd1);
      run_frame(2, 1'b0, 1'b0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule